// File: doc/BRIEF.md
# Four-Vector Parity-Tree Test Set Qualifier

This block takes four consecutive N-bit vectors and decides whether, applied as the four test patterns of a two-input XOR parity tree, they would drive every gate of a suitably shaped tree through all four of its input combinations. It checks three structural conditions on the 4-by-N matrix the vectors form: all rows differ, the rows split two-and-two between even and odd parity, and every column holds exactly two ones.

For a set that qualifies, each column is reduced to one of three sequence classes by merging every legal column pattern with its bitwise complement. The block reports how many columns fall in each class and, from the class that the XOR of all reduced columns produces, the number of tree gates whose output carries each class. A tree built on these vectors always needs N-1 gates, and the three gate counts always add up to that.

Vectors are loaded one per strobe after a start pulse. Two clock edges after the fourth vector is taken, a one-cycle done pulse marks the results as valid. The results then hold until the next start pulse.

Top module: `tsq_qualifier`

## Requirements
- R1: After a start pulse, the first four cycles with `vld_i` high capture `vec_i` as rows 0 to 3 in that order. The fourth capture is made at edge E, and `done_o` is high for exactly the one cycle that follows edge E+1.
- R2: `err_dup_o` is 1 when any two of the four captured rows are equal.
- R3: `err_par_o` is 1 when the number of rows with odd parity is not exactly two.
- R4: `err_col_o` is 1 when any column (bit c taken from rows 0 to 3) does not contain exactly two ones.
- R5: `pass_o` is 1 exactly when none of the three error flags is set.
- R6: A column's pattern is read with row 0 as the most significant bit. Patterns 0011 and 1100 count toward `cls0_o`, 0101 and 1010 toward `cls1_o`, and 0110 and 1001 toward `cls2_o`. A column of any other pattern counts toward none of them.
- R7: When the set passes, let class i be the XOR of all reduced column patterns (0011, 0101 or 0110), and let j and k be the other two classes. The gate count for class i is (nj+nk)/2. The gate counts for j and k are (ni+nk-1)/2 and (ni+nj-1)/2. When the set fails, all three gate counts are 0.
- R8: Strobes after the fourth row are ignored until the next start pulse. They produce no further done pulse and leave every result unchanged.
- R9: A start pulse discards any partly captured rows and clears every output to 0 at the next edge. Capture then begins again at row 0.
- R10: After reset, every output is 0 and the block is ready to capture row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clears the captured rows and the results |
| vld_i | input | 1 | Strobe that captures `vec_i` as the next row |
| vec_i | input | N | Test vector (row) |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| pass_o | output | 1 | The set qualifies |
| err_dup_o | output | 1 | Two rows are equal |
| err_par_o | output | 1 | The parity split is not two-and-two |
| err_col_o | output | 1 | A column does not hold exactly two ones |
| cls0_o | output | CW | Number of columns in class 0011/1100 |
| cls1_o | output | CW | Number of columns in class 0101/1010 |
| cls2_o | output | CW | Number of columns in class 0110/1001 |
| gate0_o | output | CW | Gates with output class 0011 |
| gate1_o | output | CW | Gates with output class 0101 |
| gate2_o | output | CW | Gates with output class 0110 |

## Verification
The fourth row is registered at the edge that samples its strobe. Analysis results are registered at the following edge, so `done_o` and every result field are due one full cycle after the final strobe and stay valid after it. Inputs change at falling edges and outputs are read at falling edges. The bench therefore reads results at the second falling edge after the last strobe, and it confirms at the next falling edge that `done_o` has dropped. For ignored strobes and start pulses, outputs are read one falling edge after the edge that would have acted on them.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int unsigned ROWS = 4;

  typedef logic [ROWS-1:0] colpat_t;

  localparam colpat_t PAT_C0 = 4'b0011;
  localparam colpat_t PAT_C1 = 4'b0101;
  localparam colpat_t PAT_C2 = 4'b0110;

  typedef enum logic [1:0] {
    CLS_0   = 2'd0,
    CLS_1   = 2'd1,
    CLS_2   = 2'd2,
    CLS_BAD = 2'd3
  } cls_e;

  // merge each legal pattern with its complement
  function automatic cls_e fold_class(colpat_t p);
    case (p)
      4'b0011, 4'b1100: fold_class = CLS_0;
      4'b0101, 4'b1010: fold_class = CLS_1;
      4'b0110, 4'b1001: fold_class = CLS_2;
      default:          fold_class = CLS_BAD;
    endcase
  endfunction

  function automatic colpat_t class_pat(cls_e c);
    case (c)
      CLS_0:   class_pat = PAT_C0;
      CLS_1:   class_pat = PAT_C1;
      CLS_2:   class_pat = PAT_C2;
      default: class_pat = '0;
    endcase
  endfunction
endpackage

// File: rtl/tsq_capture.sv
module tsq_capture #(
  parameter int unsigned N = 11
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_i,
  input  logic                              vld_i,
  input  logic [N-1:0]                      vec_i,
  output logic [tsq_pkg::ROWS-1:0][N-1:0]   rows_o,
  output logic                              go_o
);
  localparam int unsigned IW = $clog2(tsq_pkg::ROWS);

  logic [tsq_pkg::ROWS-1:0][N-1:0] mem_q;
  logic [IW-1:0]                   idx_q;
  logic                            full_q;
  logic                            go_q;
  logic                            wr_en;

  assign wr_en = vld_i && !full_q && !start_i;

  // row storage written without reset
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[idx_q] <= vec_i;
  end

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      idx_q  <= '0;
      full_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (wr_en) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == IW'(tsq_pkg::ROWS - 1)) begin
          full_q <= 1'b1;
          go_q   <= 1'b1;
        end
      end
    end
  end

  assign rows_o = mem_q;
  assign go_o   = go_q;
endmodule

// File: rtl/tsq_colclass.sv
module tsq_colclass #(
  parameter int unsigned N  = 11,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [tsq_pkg::ROWS-1:0][N-1:0] rows_i,
  output logic [CW-1:0]                   n0_o,
  output logic [CW-1:0]                   n1_o,
  output logic [CW-1:0]                   n2_o,
  output logic                            bad_o,
  output tsq_pkg::colpat_t                fold_x_o
);
  import tsq_pkg::*;

  cls_e cls [N];

  for (genvar c = 0; c < N; c++) begin : g_col
    colpat_t pat;
    // row 0 lands in the most significant bit
    for (genvar r = 0; r < ROWS; r++) begin : g_bit
      assign pat[ROWS-1-r] = rows_i[r][c];
    end
    assign cls[c] = fold_class(pat);
  end

  always_comb begin
    n0_o     = '0;
    n1_o     = '0;
    n2_o     = '0;
    bad_o    = 1'b0;
    fold_x_o = '0;
    for (int c = 0; c < N; c++) begin
      case (cls[c])
        CLS_0:   n0_o = n0_o + 1'b1;
        CLS_1:   n1_o = n1_o + 1'b1;
        CLS_2:   n2_o = n2_o + 1'b1;
        default: bad_o = 1'b1;
      endcase
      fold_x_o = fold_x_o ^ class_pat(cls[c]);
    end
  end
endmodule

// File: rtl/tsq_rowchk.sv
module tsq_rowchk #(
  parameter int unsigned N = 11
) (
  input  logic [tsq_pkg::ROWS-1:0][N-1:0] rows_i,
  output logic                            dup_o,
  output logic                            par_o
);
  localparam int unsigned R  = tsq_pkg::ROWS;
  localparam int unsigned NP = R * (R - 1) / 2;

  logic [NP-1:0] eq;
  logic [R-1:0]  odd;

  for (genvar a = 0; a < R; a++) begin : g_a
    assign odd[a] = ^rows_i[a];
    for (genvar b = a + 1; b < R; b++) begin : g_b
      localparam int unsigned PI = a * R - a * (a + 1) / 2 + (b - a - 1);
      assign eq[PI] = (rows_i[a] == rows_i[b]);
    end
  end

  assign dup_o = |eq;
  assign par_o = ($countones(odd) != R / 2);
endmodule

// File: rtl/tsq_gatecalc.sv
module tsq_gatecalc #(
  parameter int unsigned CW = 4
) (
  input  logic [CW-1:0]    n0_i,
  input  logic [CW-1:0]    n1_i,
  input  logic [CW-1:0]    n2_i,
  input  tsq_pkg::colpat_t fold_x_i,
  output logic [CW-1:0]    g0_o,
  output logic [CW-1:0]    g1_o,
  output logic [CW-1:0]    g2_o
);
  import tsq_pkg::*;

  logic [CW:0] s01, s02, s12;

  assign s01 = {1'b0, n0_i} + {1'b0, n1_i};
  assign s02 = {1'b0, n0_i} + {1'b0, n2_i};
  assign s12 = {1'b0, n1_i} + {1'b0, n2_i};

  // root class takes half the other two; the rest lose one first
  always_comb begin
    g0_o = '0;
    g1_o = '0;
    g2_o = '0;
    case (fold_x_i)
      PAT_C0: begin
        g0_o = CW'(s12 >> 1);
        g1_o = CW'((s02 - 1'b1) >> 1);
        g2_o = CW'((s01 - 1'b1) >> 1);
      end
      PAT_C1: begin
        g1_o = CW'(s02 >> 1);
        g0_o = CW'((s12 - 1'b1) >> 1);
        g2_o = CW'((s01 - 1'b1) >> 1);
      end
      PAT_C2: begin
        g2_o = CW'(s01 >> 1);
        g0_o = CW'((s12 - 1'b1) >> 1);
        g1_o = CW'((s02 - 1'b1) >> 1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tsq_qualifier.sv
module tsq_qualifier #(
  parameter int unsigned N  = 11,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          vld_i,
  input  logic [N-1:0]  vec_i,
  output logic          done_o,
  output logic          pass_o,
  output logic          err_dup_o,
  output logic          err_par_o,
  output logic          err_col_o,
  output logic [CW-1:0] cls0_o,
  output logic [CW-1:0] cls1_o,
  output logic [CW-1:0] cls2_o,
  output logic [CW-1:0] gate0_o,
  output logic [CW-1:0] gate1_o,
  output logic [CW-1:0] gate2_o
);
  logic [tsq_pkg::ROWS-1:0][N-1:0] rows;
  logic                            go;
  logic [CW-1:0]                   n0, n1, n2, g0, g1, g2;
  logic                            col_bad, dup, par_bad, ok;
  tsq_pkg::colpat_t                fold_x;

  tsq_capture #(.N(N)) u_cap (
    .clk(clk), .rst(rst), .start_i(start_i), .vld_i(vld_i),
    .vec_i(vec_i), .rows_o(rows), .go_o(go)
  );

  tsq_colclass #(.N(N), .CW(CW)) u_col (
    .rows_i(rows), .n0_o(n0), .n1_o(n1), .n2_o(n2),
    .bad_o(col_bad), .fold_x_o(fold_x)
  );

  tsq_rowchk #(.N(N)) u_row (
    .rows_i(rows), .dup_o(dup), .par_o(par_bad)
  );

  tsq_gatecalc #(.CW(CW)) u_gate (
    .n0_i(n0), .n1_i(n1), .n2_i(n2), .fold_x_i(fold_x),
    .g0_o(g0), .g1_o(g1), .g2_o(g2)
  );

  assign ok = !dup && !par_bad && !col_bad;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      done_o    <= 1'b0;
      pass_o    <= 1'b0;
      err_dup_o <= 1'b0;
      err_par_o <= 1'b0;
      err_col_o <= 1'b0;
      cls0_o    <= '0;
      cls1_o    <= '0;
      cls2_o    <= '0;
      gate0_o   <= '0;
      gate1_o   <= '0;
      gate2_o   <= '0;
    end else begin
      done_o <= go;
      if (go) begin
        pass_o    <= ok;
        err_dup_o <= dup;
        err_par_o <= par_bad;
        err_col_o <= col_bad;
        cls0_o    <= n0;
        cls1_o    <= n1;
        cls2_o    <= n2;
        gate0_o   <= ok ? g0 : '0;
        gate1_o   <= ok ? g1 : '0;
        gate2_o   <= ok ? g2 : '0;
      end
    end
  end
endmodule

// File: rtl/tsq_qualifier_chk.sv
module tsq_qualifier_chk #(
  parameter int unsigned N  = 11,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          done_o,
  input logic          pass_o,
  input logic          err_dup_o,
  input logic          err_par_o,
  input logic          err_col_o,
  input logic [CW-1:0] cls0_o,
  input logic [CW-1:0] cls1_o,
  input logic [CW-1:0] cls2_o,
  input logic [CW-1:0] gate0_o,
  input logic [CW-1:0] gate1_o,
  input logic [CW-1:0] gate2_o
);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5
  pass_clean_chk: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> !(err_dup_o || err_par_o || err_col_o));

  // R7
  gate_total_chk: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> (int'(gate0_o) + int'(gate1_o) + int'(gate2_o) == int'(N) - 1));

  // R7
  gate_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !pass_o |-> (gate0_o == '0 && gate1_o == '0 && gate2_o == '0));

  // R6
  class_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(cls0_o) + int'(cls1_o) + int'(cls2_o) <= int'(N)));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!done_o && !pass_o && cls0_o == '0 && cls1_o == '0 && cls2_o == '0));
endmodule

bind tsq_qualifier tsq_qualifier_chk #(.N(N), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
  .pass_o(pass_o), .err_dup_o(err_dup_o), .err_par_o(err_par_o),
  .err_col_o(err_col_o), .cls0_o(cls0_o), .cls1_o(cls1_o),
  .cls2_o(cls2_o), .gate0_o(gate0_o), .gate1_o(gate1_o),
  .gate2_o(gate2_o)
);

// File: tb/tsq_qualifier_tb.sv
`timescale 1ns/1ps
module tsq_qualifier_tb;
  localparam int unsigned N  = 11;
  localparam int unsigned CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          vld_i = 1'b0;
  logic [N-1:0]  vec_i = '0;
  logic          done_o, pass_o, err_dup_o, err_par_o, err_col_o;
  logic [CW-1:0] cls0_o, cls1_o, cls2_o, gate0_o, gate1_o, gate2_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tsq_qualifier #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .vld_i(vld_i), .vec_i(vec_i),
    .done_o(done_o), .pass_o(pass_o), .err_dup_o(err_dup_o),
    .err_par_o(err_par_o), .err_col_o(err_col_o),
    .cls0_o(cls0_o), .cls1_o(cls1_o), .cls2_o(cls2_o),
    .gate0_o(gate0_o), .gate1_o(gate1_o), .gate2_o(gate2_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic push(logic [N-1:0] v);
    vld_i = 1'b1;
    vec_i = v;
    @(negedge clk);
    vld_i = 1'b0;
  endtask

  task automatic check_outs(int ps, int d, int p, int c, int n0, int n1, int n2,
                            int g0, int g1, int g2);
    chk("R5", "pass", pass_o, ps);
    chk("R2", "dup", err_dup_o, d);
    chk("R3", "parity", err_par_o, p);
    chk("R4", "column", err_col_o, c);
    chk("R6", "cls0", cls0_o, n0);
    chk("R6", "cls1", cls1_o, n1);
    chk("R6", "cls2", cls2_o, n2);
    chk("R7", "gate0", gate0_o, g0);
    chk("R7", "gate1", gate1_o, g1);
    chk("R7", "gate2", gate2_o, g2);
  endtask

  // start, four rows, results due at the second falling edge after the last strobe
  task automatic run_set(logic [N-1:0] r0, r1, r2, r3, int ps, int d, int p, int c,
                         int n0, int n1, int n2, int g0, int g1, int g2);
    pulse_start();
    push(r0); push(r1); push(r2); push(r3);
    chk("R1", "done early", done_o, 0);
    @(negedge clk);
    chk("R1", "done", done_o, 1);
    check_outs(ps, d, p, c, n0, n1, n2, g0, g1, g2);
    @(negedge clk);
    chk("R1", "done width", done_o, 0);
  endtask

  task automatic t_reset();
    // R10
    chk("R10", "done", done_o, 0);
    check_outs(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_pass_root0();
    // 7 cols 0011, 2 cols 0101, 2 cols 0110: root class 0 -> gates 2,4,4
    run_set(11'h000, 11'h780, 11'h67F, 11'h1FF, 1, 0, 0, 0, 7, 2, 2, 2, 4, 4);
  endtask

  task automatic t_pass_complement();
    // column 0 complemented to 1100, same class: R6 folding
    run_set(11'h001, 11'h781, 11'h67E, 11'h1FE, 1, 0, 0, 0, 7, 2, 2, 2, 4, 4);
  endtask

  task automatic t_pass_root1();
    // col0 0101, ten cols 0011: root class 1 -> gates 0,5,5
    run_set(11'h000, 11'h001, 11'h7FE, 11'h7FF, 1, 0, 0, 0, 10, 1, 0, 0, 5, 5);
  endtask

  task automatic t_dup_only();
    run_set(11'h000, 11'h000, 11'h7FF, 11'h7FF, 0, 1, 0, 0, 11, 0, 0, 0, 0, 0);
  endtask

  task automatic t_par_only();
    // XOR of columns is 0000: all rows even
    run_set(11'h000, 11'h006, 11'h7FD, 11'h7FB, 0, 0, 1, 0, 9, 1, 1, 0, 0, 0);
  endtask

  task automatic t_col_only();
    run_set(11'h000, 11'h001, 11'h002, 11'h003, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_ignore_extra();
    // R8: results from root-1 set must survive extra strobes
    run_set(11'h000, 11'h001, 11'h7FE, 11'h7FF, 1, 0, 0, 0, 10, 1, 0, 0, 5, 5);
    push(11'h000); push(11'h555); push(11'h2AA); push(11'h7FF);
    @(negedge clk);
    chk("R8", "no second done", done_o, 0);
    @(negedge clk);
    chk("R8", "no late done", done_o, 0);
    chk("R8", "pass held", pass_o, 1);
    chk("R8", "cls0 held", cls0_o, 10);
    chk("R8", "gate2 held", gate2_o, 5);
  endtask

  task automatic t_restart();
    // R9: start clears outputs, partial rows discarded
    pulse_start();
    chk("R9", "pass cleared", pass_o, 0);
    chk("R9", "cls0 cleared", cls0_o, 0);
    chk("R9", "gate1 cleared", gate1_o, 0);
    push(11'h123); push(11'h123);
    chk("R9", "no done partial", done_o, 0);
    run_set(11'h000, 11'h780, 11'h67F, 11'h1FF, 1, 0, 0, 0, 7, 2, 2, 2, 4, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pass_root0();
    t_pass_complement();
    t_pass_root1();
    t_dup_only();
    t_par_only();
    t_col_only();
    t_ignore_extra();
    t_restart();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule